// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is one DMA channel that copies packets of 32-bit words from a source area to a destination area. Each packet is described by a four-word descriptor. Software programs the first descriptor straight into the channel registers, then writes the configuration register with its enable bit set. From then on the channel runs without help: it moves the packet in bursts of up to four words, fetches the next descriptor from memory through the same port, and stops when the link of the current descriptor is null.

Memory is reached through one word-wide port with a request/grant handshake. The channel holds its request, direction, address and write data until a cycle where `mem_gnt` is high. That cycle completes the access, and read data is taken from `mem_rdata` in the same cycle. A descriptor can ask for a terminal-count event when its packet ends. The event sets a sticky status bit. The status drives the interrupt through a mask bit held in the configuration register, which is written only by software.

Register map on `reg_addr`: 0 source address, 1 destination address, 2 link, 3 control, 4 configuration, 5 terminal-count clear. Control word fields: word count in bits [11:0], source increment in bit 26, destination increment in bit 27, terminal-count request in bit 31. Configuration fields: enable in bit 0, interrupt mask in bit 1. Registers 0 to 4 are written only while the channel is idle.

States and transitions:
- IDLE to EVAL when enable is set.
- EVAL to DONE on a zero remaining count; otherwise EVAL to READ with a burst of min(count, 4) words.
- READ to WRITE after the last granted read beat.
- WRITE to EVAL after the last granted write beat.
- DONE to IDLE on a null link, clearing enable; otherwise DONE to FETCH.
- FETCH to EVAL after the fourth descriptor word.

Top module: `sg_dma_chan`

## Requirements
- R1: After reset, `chan_en`, `tc_status`, `irq` and `mem_req` are all 0.
- R2: Writing register 4 with bit 0 set starts a transfer using the descriptor held in registers 0 to 3. Each of the count words is read from the source and written to the destination, so a count of N makes 2N data accesses.
- R3: Control bit 26 makes the source address step by 4 after each word, and bit 27 does the same for the destination. An address whose bit is clear stays fixed, so a fixed destination ends up holding the last word read.
- R4: Data moves in bursts of min(remaining, 4) reads, and all reads of a burst complete before its writes. No more than 4 data reads occur between writes.
- R5: A descriptor fetch reads the four words at pointer, pointer+4, pointer+8 and pointer+12, in that order. It loads them as source, destination, link and control. The pointer's two low bits are ignored.
- R6: A link whose bits [31:2] are all zero ends the chain. After that packet, `chan_en` drops to 0 and no further requests are made.
- R7: The configuration register is never loaded from memory. The interrupt mask written by software is still in force after a chain walk.
- R8: `tc_status` is set at the end of a descriptor's packet only when that descriptor's control bit 31 is set.
- R9: `tc_status` stays set until register 5 is written with bit 0 set. A write with bit 0 clear leaves it set.
- R10: `irq` equals `tc_status` AND configuration bit 1.
- R11: A descriptor with a count of 0 completes with no data access and its link is then followed.
- R12: While `mem_req` is high and not granted, the request, its direction and its address hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; completes the access in this cycle |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| chan_en | output | 1 | Channel enable, cleared at chain end |
| tc_status | output | 1 | Sticky terminal-count status |
| irq | output | 1 | Masked terminal-count interrupt |

## Verification
A register write lands on the clock edge after the strobe is driven. `chan_en` therefore reads 1 at the following falling edge, and a clear write shows on `tc_status` and `irq` one cycle after it. Data results are not tied to a cycle count, because the grant pattern stretches each access. The bench instead polls `chan_en` at falling edges until it drops, and only then compares the destination words against a model computed from the count and increment bits. Burst lengths, access counts and fetch addresses are recorded at each granted edge and compared once the channel is idle again.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FETCH
    } sg_state_e;

    localparam logic [2:0] RA_SRC   = 3'd0;
    localparam logic [2:0] RA_DST   = 3'd1;
    localparam logic [2:0] RA_LINK  = 3'd2;
    localparam logic [2:0] RA_CTRL  = 3'd3;
    localparam logic [2:0] RA_CFG   = 3'd4;
    localparam logic [2:0] RA_TCCLR = 3'd5;

    localparam int CB_SINC = 26;
    localparam int CB_DINC = 27;
    localparam int CB_TC   = 31;
    localparam int FB_EN   = 0;
    localparam int FB_MSK  = 1;

    localparam int DESC_WORDS = 4;

endpackage

// File: rtl/sgdma_beat_buf.sv
module sgdma_beat_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                slot[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/sgdma_tc_irq.sv
module sgdma_tc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic status_o,
    output logic irq_o
);

    logic status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (set_i) begin
            status_q <= 1'b1;
        end else if (clr_i) begin
            status_q <= 1'b0;
        end
    end

    assign status_o = status_q;
    assign irq_o    = status_q & mask_i;

endmodule

// File: rtl/sg_dma_chan.sv
module sg_dma_chan #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int BURST  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              chan_en,
    output logic              tc_status,
    output logic              irq
);
    import sgdma_pkg::*;

    localparam int BIDX_W = (BURST > 1) ? $clog2(BURST) : 1;
    localparam int BLEN_W = $clog2(BURST + 1);
    localparam int STEP   = DATA_W / 8;
    localparam int LINK_W = ADDR_W - 2;

    sg_state_e state_q, state_d;

    logic [ADDR_W-1:0] src_q, dst_q, fptr_q;
    logic [LINK_W-1:0] link_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sinc_q, dinc_q, tc_q;
    logic              cfg_en_q, cfg_msk_q;
    logic [BIDX_W-1:0] idx_q;
    logic [BLEN_W-1:0] blen_q, burst_len;
    logic [1:0]        fidx_q;

    logic              beat_done, last_beat, link_null, sw_wr;
    logic              tc_set, fetch_active, buf_wr;
    logic [DATA_W-1:0] buf_rd;
    logic [ADDR_W-1:0] src_step, dst_step;

    assign beat_done    = mem_req && mem_gnt;
    assign last_beat    = (BLEN_W'(idx_q) + BLEN_W'(1)) == blen_q;
    assign link_null    = (link_q == '0);
    assign sw_wr        = reg_wr && (state_q == ST_IDLE);
    assign src_step     = sinc_q ? ADDR_W'(STEP) : '0;
    assign dst_step     = dinc_q ? ADDR_W'(STEP) : '0;
    assign fetch_active = (state_q == ST_FETCH);
    assign buf_wr       = (state_q == ST_READ) && beat_done;

    always_comb begin
        if (cnt_q >= CNT_W'(BURST)) begin
            burst_len = BLEN_W'(BURST);
        end else begin
            burst_len = BLEN_W'(cnt_q);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cfg_en_q) state_d = ST_EVAL;
            ST_EVAL:  state_d = (cnt_q == '0) ? ST_DONE : ST_READ;
            ST_READ:  if (beat_done && last_beat) state_d = ST_WRITE;
            ST_WRITE: if (beat_done && last_beat) state_d = ST_EVAL;
            ST_DONE:  state_d = link_null ? ST_IDLE : ST_FETCH;
            ST_FETCH: if (beat_done && (fidx_q == 2'(DESC_WORDS - 1))) state_d = ST_EVAL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tc_set    = 1'b0;
        unique case (state_q)
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = buf_rd;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = fptr_q + ADDR_W'(fidx_q) * ADDR_W'(STEP);
            end
            ST_DONE: tc_set = tc_q;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            dst_q     <= '0;
            fptr_q    <= '0;
            link_q    <= '0;
            cnt_q     <= '0;
            sinc_q    <= 1'b0;
            dinc_q    <= 1'b0;
            tc_q      <= 1'b0;
            cfg_en_q  <= 1'b0;
            cfg_msk_q <= 1'b0;
            idx_q     <= '0;
            blen_q    <= '0;
            fidx_q    <= '0;
        end else begin
            if (sw_wr) begin
                unique case (reg_addr)
                    RA_SRC:  src_q  <= ADDR_W'(reg_wdata);
                    RA_DST:  dst_q  <= ADDR_W'(reg_wdata);
                    RA_LINK: link_q <= LINK_W'(reg_wdata >> 2);
                    RA_CTRL: begin
                        cnt_q  <= reg_wdata[CNT_W-1:0];
                        sinc_q <= reg_wdata[CB_SINC];
                        dinc_q <= reg_wdata[CB_DINC];
                        tc_q   <= reg_wdata[CB_TC];
                    end
                    RA_CFG: begin
                        cfg_en_q  <= reg_wdata[FB_EN];
                        cfg_msk_q <= reg_wdata[FB_MSK];
                    end
                    default: ;
                endcase
            end
            unique case (state_q)
                ST_EVAL: begin
                    idx_q  <= '0;
                    blen_q <= burst_len;
                end
                ST_READ: if (beat_done) begin
                    src_q <= src_q + src_step;
                    idx_q <= last_beat ? '0 : idx_q + BIDX_W'(1);
                end
                ST_WRITE: if (beat_done) begin
                    dst_q <= dst_q + dst_step;
                    cnt_q <= cnt_q - CNT_W'(1);
                    idx_q <= last_beat ? '0 : idx_q + BIDX_W'(1);
                end
                ST_DONE: begin
                    fptr_q <= {link_q, 2'b00};
                    fidx_q <= '0;
                    if (link_null) cfg_en_q <= 1'b0;
                end
                ST_FETCH: if (beat_done) begin
                    unique case (fidx_q)
                        2'd0: src_q  <= ADDR_W'(mem_rdata);
                        2'd1: dst_q  <= ADDR_W'(mem_rdata);
                        2'd2: link_q <= LINK_W'(mem_rdata >> 2);
                        default: begin
                            cnt_q  <= mem_rdata[CNT_W-1:0];
                            sinc_q <= mem_rdata[CB_SINC];
                            dinc_q <= mem_rdata[CB_DINC];
                            tc_q   <= mem_rdata[CB_TC];
                        end
                    endcase
                    fidx_q <= fidx_q + 2'd1;
                end
                default: ;
            endcase
        end
    end

    sgdma_beat_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (BURST)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_idx  (idx_q),
        .wr_data (mem_rdata),
        .rd_idx  (idx_q),
        .rd_data (buf_rd)
    );

    sgdma_tc_irq u_tc (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (tc_set),
        .clr_i    (reg_wr && (reg_addr == RA_TCCLR) && reg_wdata[0]),
        .mask_i   (cfg_msk_q),
        .status_o (tc_status),
        .irq_o    (irq)
    );

    assign chan_en = cfg_en_q;

endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk #(
    parameter int ADDR_W = 32,
    parameter int BURST  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic              reg_bit0,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              chan_en,
    input logic              tc_status,
    input logic              irq,
    input logic              tc_set,
    input logic              fetch_active
);

    logic       clr_wr;
    logic [7:0] rd_run;

    assign clr_wr = reg_wr && (reg_addr == 3'd5) && reg_bit0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_run <= '0;
        end else if (mem_req && mem_gnt && mem_we) begin
            rd_run <= '0;
        end else if (mem_req && mem_gnt && !fetch_active && (rd_run != 8'hFF)) begin
            rd_run <= rd_run + 8'd1;
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_en) |-> !mem_req);

    // R9
    tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_status && !clr_wr) |=> tc_status);

    // R9
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !tc_set) |=> !tc_status);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tc_status);

    // R5
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_active |-> (mem_addr[1:0] == 2'b00 && !mem_we));

    // R4
    burst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !mem_we && !fetch_active) |-> (rd_run < 8'(BURST)));

endmodule

bind sg_dma_chan sgdma_chk #(
    .ADDR_W (ADDR_W),
    .BURST  (BURST)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_bit0     (reg_wdata[0]),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_gnt      (mem_gnt),
    .chan_en      (chan_en),
    .tc_status    (tc_status),
    .irq          (irq),
    .tc_set       (tc_set),
    .fetch_active (fetch_active)
);

// File: tb/test_sg_dma_chan.sv
module test_sg_dma_chan;

    localparam logic [31:0] FILL = 32'h5A5A_5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        chan_en, tc_status, irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [512];
    logic        gnt_mode = 1'b0;
    int          stall_ctr = 0;

    int          rd_run = 0, max_run = 0, data_acc = 0, fetch_cnt = 0, hold_bad = 0;
    logic [31:0] fetch_addr [8];
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    always #5 clk = ~clk;

    sg_dma_chan i_sg_dma_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .chan_en   (chan_en),
        .tc_status (tc_status),
        .irq       (irq)
    );

    assign mem_rdata = mem[mem_addr[10:2]];

    always @(negedge clk) begin
        stall_ctr <= stall_ctr + 1;
    end
    assign mem_gnt = gnt_mode ? ((stall_ctr % 3) != 0) : 1'b1;

    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_wait && !(mem_req && mem_addr == prev_addr)) hold_bad <= hold_bad + 1;
            prev_wait <= mem_req && !mem_gnt;
            prev_addr <= mem_addr;
            if (mem_req && mem_gnt) begin
                if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
                if (mem_addr < 32'd1024) begin
                    data_acc <= data_acc + 1;
                    if (mem_we) begin
                        rd_run <= 0;
                    end else begin
                        rd_run <= rd_run + 1;
                        if (rd_run + 1 > max_run) max_run <= rd_run + 1;
                    end
                end else if (!mem_we) begin
                    if (fetch_cnt < 8) fetch_addr[fetch_cnt] <= mem_addr;
                    fetch_cnt <= fetch_cnt + 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [31:0] pat(int i);
        return 32'hA000_0000 + 32'(i) * 32'h0001_0107;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic init_mem();
        @(negedge clk);
        for (int i = 0; i < 512; i++) mem[i] = (i >= 128 && i < 256) ? FILL : pat(i);
        rd_run = 0;
        max_run = 0;
        data_acc = 0;
        fetch_cnt = 0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        @(negedge clk);
        while (chan_en && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [31:0] exp_w [12];
        int n_exp;

        repeat (3) @(negedge clk);
        // R1 reset values
        check(!chan_en && !tc_status && !irq && !mem_req, "R1 reset outputs",
              {28'd0, chan_en, tc_status, irq, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Single-descriptor sweep over counts and increment modes
        for (int n = 0; n < 10; n++) begin
            for (int m = 0; m < 4; m++) begin
                logic si, di;
                si = m[0];
                di = m[1];
                gnt_mode = ((n + m) % 2) == 1;
                init_mem();
                reg_write(3'd0, 32'(4 * (4 + n)));
                reg_write(3'd1, 32'(4 * 140));
                reg_write(3'd2, 32'd0);
                reg_write(3'd3, {4'b0, di, si, 14'd0, 12'(n)});
                reg_write(3'd4, 32'd1);
                // R2 enable visible one edge after the write
                check(chan_en || n == 0, "R2 start", {31'd0, chan_en}, 32'd1);
                wait_idle();
                for (int k = 0; k < 12; k++) exp_w[k] = FILL;
                for (int k = 0; k < n; k++) exp_w[di ? k : 0] = pat(4 + n + (si ? k : 0));
                for (int k = 0; k < 12; k++)
                    // R3 increment or fixed addressing, R2 data copy
                    check(mem[140 + k] === exp_w[k], "R3 R2 dest word", mem[140 + k], exp_w[k]);
                // R6 stop on null link
                check(!chan_en, "R6 enable cleared", {31'd0, chan_en}, 32'd0);
                // R4 burst length
                n_exp = (n < 4) ? n : 4;
                check(max_run == n_exp, "R4 max read run", 32'(max_run), 32'(n_exp));
                // R11 / R2 access count
                check(data_acc == 2 * n, "R11 R2 data accesses", 32'(data_acc), 32'(2 * n));
                // R8 no tc request
                check(!tc_status, "R8 no tc", {31'd0, tc_status}, 32'd0);
            end
        end

        // Chain: regs -> words 300 (ptr with low bits set) -> 304 -> null
        init_mem();
        gnt_mode = 1'b1;
        mem[300] = 32'(4 * 20);
        mem[301] = 32'(4 * 170);
        mem[302] = 32'(4 * 304);
        mem[303] = 32'h8C00_0000;            // tc, both inc, count 0
        mem[304] = 32'(4 * 30);
        mem[305] = 32'(4 * 180);
        mem[306] = 32'd0;
        mem[307] = 32'h0400_0003;            // src inc only, count 3
        reg_write(3'd0, 32'd0);
        reg_write(3'd1, 32'(4 * 160));
        reg_write(3'd2, 32'(4 * 300) | 32'd3);
        reg_write(3'd3, 32'h0C00_0005);
        reg_write(3'd4, 32'd3);
        wait_idle();
        for (int k = 0; k < 5; k++)
            check(mem[160 + k] === pat(k), "R2 chain first packet", mem[160 + k], pat(k));
        // R11 zero-count descriptor made no access to its area
        check(mem[170] === FILL, "R11 zero count untouched", mem[170], FILL);
        check(data_acc == 16, "R11 chain data accesses", 32'(data_acc), 32'd16);
        // R3 fixed destination keeps last word
        check(mem[180] === pat(32), "R3 fixed dest", mem[180], pat(32));
        check(mem[181] === FILL, "R3 fixed dest neighbour", mem[181], FILL);
        // R5 fetch order and addresses
        check(fetch_cnt == 8, "R5 fetch count", 32'(fetch_cnt), 32'd8);
        for (int k = 0; k < 8; k++)
            check(fetch_addr[k] == 32'(1200 + 4 * k), "R5 fetch address", fetch_addr[k], 32'(1200 + 4 * k));
        check(!chan_en, "R6 chain end", {31'd0, chan_en}, 32'd0);
        // R8 tc from middle descriptor
        check(tc_status, "R8 tc set", {31'd0, tc_status}, 32'd1);
        // R7 R10 mask survives the chain
        check(irq, "R7 R10 irq with mask", {31'd0, irq}, 32'd1);

        // R9 clear behaviour
        reg_write(3'd5, 32'd0);
        check(tc_status, "R9 zero write keeps", {31'd0, tc_status}, 32'd1);
        reg_write(3'd5, 32'd1);
        check(!tc_status && !irq, "R9 clear", {30'd0, tc_status, irq}, 32'd0);

        // R10 mask off, then on
        init_mem();
        gnt_mode = 1'b0;
        reg_write(3'd0, 32'd0);
        reg_write(3'd1, 32'(4 * 150));
        reg_write(3'd2, 32'd0);
        reg_write(3'd3, 32'h8C00_0002);
        reg_write(3'd4, 32'd1);
        wait_idle();
        check(tc_status, "R8 tc single", {31'd0, tc_status}, 32'd1);
        check(!irq, "R10 masked", {31'd0, irq}, 32'd0);
        reg_write(3'd4, 32'd2);
        check(irq && !chan_en, "R10 unmasked", {30'd0, irq, chan_en}, 32'd2);

        // R12 handshake hold
        check(hold_bad == 0, "R12 request hold", 32'(hold_bad), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule